// File: doc/BRIEF.md
# Host Byte-to-Word Read Unpacker

This block lets a host with a byte-wide register port read a stream of 64-bit memory words one byte at a time. The host loads a source address a byte at a time into a staging register. Writing the least significant address byte starts a read operation: the word FIFO is flushed, the fetch pointer is set to the staged address, and the block issues word fetches to memory until the FIFO holds `DEPTH` words. Each read of the data register returns one byte of the word at the FIFO head. After the eighth byte of a word has been read, that word is released and its slot is refetched.

A control register bit selects the byte order within a word. Two status outputs, empty and full, tell the host when a data read is allowed and when a new operation may start. Memory is reached through a request/acknowledge handshake. The request holds its address until it is acknowledged, and the response word is valid in the acknowledge cycle for the address shown in that cycle.

Top module: `host_rd_unpack`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, `host_rdata` is 0 and `mem_req` is 0.
- R2: Register selects 0 to ADDR_W/8-1 are the address bytes, and select 0 is the least significant byte. A write to select 0 that is accepted sets `mem_addr` to the staged upper bytes joined with the written byte, from the next cycle on.
- R3: Each acknowledged fetch adds 8 to `mem_addr`. Fetching continues while the FIFO holds fewer than DEPTH words. When it holds DEPTH words, `fifo_full` is 1, `mem_req` is 0 and `mem_addr` is the start address plus 8*DEPTH.
- R4: A read of the data register (select ADDR_W/8+1) while the FIFO is not empty returns one byte. In the default order, byte k of the head word is bits [8k+7:8k], and k counts 0 to 7 over successive reads.
- R5: After the eighth byte read of a word, the next read returns byte 0 of the next fetched word (start address plus 8 for the second word, and so on).
- R6: A data read while `fifo_empty` is 1 leaves `host_rdata` unchanged and moves no pointer. Once data arrives, reads resume at byte 0 of the first word.
- R7: When bit 0 of the control register (select ADDR_W/8) is 1, byte k of a word is bits [63-8k:56-8k].
- R8: A write to select 0 while an operation is active and `fifo_full` is 0 does not start a new operation. Reads continue with the old byte stream.
- R9: An accepted start flushes the FIFO. On the next cycle `fifo_empty` is 1 and `fifo_full` is 0, and no old word is ever returned.
- R10: The status flags change in the cycle after the access that changes them. `fifo_full` falls after the read of the last byte of a word taken from a full FIFO. `fifo_empty` rises after the read of the last byte of the last stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | SEL_W | Register select |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Last byte read from the data register |
| fifo_empty | output | 1 | No word is available for reading |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Fetch acknowledge, data valid this cycle |
| mem_rdata | input | 64 | Fetched word |

## Verification
A wrong byte position shows as a misordered or repeated byte on `host_rdata` within eight reads. A head pointer that moves too early or too late shows as a word boundary in the wrong place, seen at the ninth read. A count that is off shows as `fifo_full` or `fifo_empty` flipping one read early or late when a full FIFO is drained against a stalled memory. A fetch pointer that is stale or not cleared shows as bytes from the wrong address on the first word after a start.

// File: rtl/host_rd_unpack.sv
module host_rd_unpack #(
  parameter int DEPTH = 4,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(ADDR_W / 8 + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);
  localparam int AB = ADDR_W / 8;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(AB);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(AB + 1);

  logic [ADDR_W-1:0] stage_q, fetch_q;
  logic              active_q, be_q;
  logic [63:0]       word_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bpos_q;
  logic [7:0]        rdata_q;

  assign fifo_empty = (cnt_q == '0);
  assign fifo_full  = (cnt_q == CNT_W'(DEPTH));
  assign mem_req    = active_q && !fifo_full;
  assign mem_addr   = fetch_q;
  assign host_rdata = rdata_q;

  wire start   = host_wr && (host_sel == '0) && (!active_q || fifo_full);
  wire data_rd = host_rd && (host_sel == SEL_DATA) && !fifo_empty;
  wire push    = mem_req && mem_ack && !start;
  wire pop     = data_rd && (bpos_q == 3'd7);

  wire [2:0]  lane     = be_q ? (3'd7 - bpos_q) : bpos_q;
  wire [63:0] head_w   = word_q[head_q];
  wire [7:0]  cur_byte = head_w[{lane, 3'b000} +: 8];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      be_q    <= 1'b0;
    end else if (host_wr) begin
      if (host_sel == SEL_CTRL) be_q <= host_wdata[0];
      for (int i = 0; i < AB; i++)
        if (host_sel == SEL_W'(i)) stage_q[i*8 +: 8] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (data_rd) rdata_q <= cur_byte;
  end

  always_ff @(posedge clk) begin
    if (push) word_q[tail_q] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fetch_q  <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      bpos_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      fetch_q  <= {stage_q[ADDR_W-1:8], host_wdata};
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      bpos_q   <= '0;
    end else begin
      if (push) begin
        fetch_q <= fetch_q + ADDR_W'(8);
        tail_q  <= nxt(tail_q);
      end
      if (pop) head_q <= nxt(head_q);
      if (data_rd) bpos_q <= bpos_q + 3'd1;
      if (push && !pop) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/host_rd_unpack_chk.sv
module host_rd_unpack_chk #(
  parameter int SEL_W = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_SEL = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic [SEL_W-1:0]  host_sel,
  input logic [7:0]        host_rdata,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              start
);
  wire data_sel_rd = host_rd && (host_sel == SEL_W'(DATA_SEL));

  // R3
  full_stops_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !mem_req);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !start) |=> (mem_addr == $past(mem_addr) + ADDR_W'(8)));

  // R6
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_sel_rd && fifo_empty) |=> $stable(host_rdata));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (fifo_empty && !fifo_full));

  // R10
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_empty) |-> $past(start || data_sel_rd));

  // R10
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_full) |-> $past(mem_req && mem_ack));
endmodule

bind host_rd_unpack host_rd_unpack_chk #(
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_SEL(ADDR_W / 8 + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_sel(host_sel),
  .host_rdata(host_rdata), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .start(start)
);

// File: tb/host_rd_unpack_bench.sv
module host_rd_unpack_bench;
  localparam int DEPTH = 4;
  localparam int ADDR_W = 32;
  localparam int SEL_W = 3;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [SEL_W-1:0] host_sel = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic fifo_empty, fifo_full, mem_req, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0] mem_rdata;
  logic stall = 0;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pb(input logic [31:0] a, input int k);
    return (a[7:0] + 8'(k)) ^ a[15:8];
  endfunction

  always_comb
    for (int k = 0; k < 8; k++) mem_rdata[k*8 +: 8] = pb(mem_addr, k);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack && !stall;

  host_rd_unpack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_host_rd_unpack (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [SEL_W-1:0] s, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_sel = s; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); host_rd = 1; host_sel = 3'd5;
    @(negedge clk); host_rd = 0; b = host_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    wr_reg(3'd3, a[31:24]); wr_reg(3'd2, a[23:16]);
    wr_reg(3'd1, a[15:8]);  wr_reg(3'd0, a[7:0]);
  endtask

  task automatic wait_full(input string req);
    for (int i = 0; i < 60 && !fifo_full; i++) @(negedge clk);
    chk(req, fifo_full, 1);
  endtask

  logic [31:0] A = 32'h0012_3440, B = 32'h00AB_5608;
  logic [7:0] b, last;

  task automatic t_reset();
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 rdata", host_rdata, 0);
    chk("R1 req", mem_req, 0);
  endtask

  task automatic t_stream();
    set_addr(A);
    chk("R2 mem_addr", mem_addr, A);
    chk("R9 empty after start", fifo_empty, 1);
    wait_full("R3 full");
    chk("R3 req low", mem_req, 0);
    chk("R3 fetch addr", mem_addr, A + 8 * DEPTH);
    for (int k = 0; k < 8; k++) begin
      rd_byte(b); chk("R4 le byte", b, pb(A, k));
    end
    wr_reg(3'd0, 8'hC0);
    rd_byte(b); chk("R5 R8 next word byte0", b, pb(A + 8, 0));
    for (int k = 1; k < 8; k++) begin
      rd_byte(b); chk("R8 old stream", b, pb(A + 8, k));
    end
  endtask

  task automatic t_empty();
    wait_full("R9 full before restart");
    stall = 1;
    last = host_rdata;
    set_addr(B);
    chk("R9 empty", fifo_empty, 1);
    chk("R9 not full", fifo_full, 0);
    rd_byte(b); chk("R6 hold rdata", b, last);
    chk("R6 still empty", fifo_empty, 1);
    stall = 0;
    wait_full("R6 refill");
    for (int k = 0; k < 8; k++) begin
      rd_byte(b); chk("R6 R9 new data", b, pb(B, k));
    end
  endtask

  task automatic t_order();
    wr_reg(3'd4, 8'h01);
    for (int k = 0; k < 8; k++) begin
      rd_byte(b); chk("R7 be byte", b, pb(B + 8, 7 - k));
    end
    wr_reg(3'd4, 8'h00);
  endtask

  task automatic t_flags();
    wait_full("R10 full");
    stall = 1;
    for (int w = 0; w < DEPTH; w++)
      for (int k = 0; k < 8; k++) begin
        rd_byte(b);
        chk("R5 drain data", b, pb(B + 16 + 8 * w, k));
        if (w == 0 && k == 6) chk("R10 full held", fifo_full, 1);
        if (w == 0 && k == 7) chk("R10 full falls", fifo_full, 0);
        if (w == DEPTH - 1 && k == 7) chk("R10 empty rises", fifo_empty, 1);
        else chk("R10 not empty", fifo_empty, 0);
      end
    stall = 0;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_empty();
    t_order();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule